// File: doc/BRIEF.md
# Framebuffer Scan-Out Address Generator

This block feeds a fixed 640 by 480 true-colour display from a framebuffer held in word-wide memory. An external raster timing generator supplies the current pixel position with a valid strobe. The block turns each visible position into a byte address for memory and issues a one-cycle read request. It then splits the returned 32-bit word into 8-bit red, green and blue outputs, which appear a fixed three cycles after the position was presented.

Two programmable registers sit on a simple 32-bit register bus. One holds the frame origin, of which only the top 11 bits are kept, so a frame always starts on a 2 MiB boundary. The other holds an enable bit and a half-turn bit. Every memory row is 1024 words long, but only the first 640 words are ever read. With the half-turn bit set, the whole scan runs backwards, so the picture appears rotated by 180 degrees. Register writes take effect at once on read-back, but the scan engine only picks them up at the next frame-start pulse, so a frame never shows two settings.

Top module: `fbscan_top`

## Requirements
- R1: After reset both registers read as zero, the display is disabled, no memory request is issued and the colour outputs are zero.
- R2: Byte offset bit 2 of `reg_addr` selects the register (0 = frame origin, 1 = control) and bits 1:0 are ignored. A read returns the programmed value on `reg_rdata` one cycle after `reg_rd`. Control keeps only bit 0 (enable) and bit 1 (half-turn), and its other bits read as zero.
- R3: For a visible pixel (col, row) with the display enabled and no half-turn, `mem_req` is high for exactly the cycle after the position is sampled, and `mem_addr` = origin + 4*(row*1024 + col) in that cycle.
- R4: Only bits 31:21 of a written origin are kept. Bits 20:0 read back as zero and have no effect on `mem_addr`.
- R5: The returned word is unpacked as red = bits 23:16, green = bits 15:8 and blue = bits 7:0. Bits 31:24 have no effect on the outputs.
- R6: While the applied enable bit is clear, no memory request is issued and the colour outputs stay zero.
- R7: With the applied half-turn bit set, pixel (col, row) is fetched from address origin + 4*((479-row)*1024 + (639-col)).
- R8: A position with col >= 640 or row >= 480 issues no memory request and yields zero colour outputs.
- R9: `px_valid` equals `pix_valid` delayed by exactly three cycles. The colour outputs are zero whenever `px_valid` is low, and when a fetch was made they carry the data returned one cycle after the request.
- R10: A register write reaches the scan engine only at a `frame_start` pulse. Pixels sampled after the cycle of the pulse use the new values. A write in the same cycle as the pulse waits for the following pulse.
- R11: Writing zero to control turns the display off at the next frame start. Writing the enable bit alone or together with the half-turn bit turns it back on. Writing only the half-turn bit leaves it off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register byte offset (bit 2 selects) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| frame_start | input | 1 | Pulse that applies pending register values |
| pix_valid | input | 1 | Raster position valid |
| pix_col | input | 10 | Raster column |
| pix_row | input | 9 | Raster row |
| mem_req | output | 1 | Framebuffer read request |
| mem_addr | output | 32 | Framebuffer byte address |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_req` |
| px_valid | output | 1 | Output pixel valid |
| px_red | output | 8 | Red level |
| px_green | output | 8 | Green level |
| px_blue | output | 8 | Blue level |

## Verification
The hardest situation to reach from the ports is a register value that is visible on read-back but not yet applied. Another is a write that lands in the very cycle of a frame-start pulse. The stimulus writes new control or origin values and then scans pixels before any pulse, which shows that the old settings still drive the addresses. It then drives a write and a pulse on the same clock edge and scans again across two pulses. Back-to-back pixel bursts that mix the four screen corners with off-screen positions keep the three-stage pipeline full, so blank and fetched pixels sit next to each other.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

  // Control register layout: enable in bit 0, half-turn in bit 1.
  typedef struct packed {
    logic rotate;
    logic enable;
  } scan_ctrl_t;

  localparam int unsigned CTRL_W = $bits(scan_ctrl_t);

endpackage

// File: rtl/fbscan_regs.sv
module fbscan_regs
  import fbscan_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BASE_BITS = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic                 sel_ctrl,
  input  logic [AW-1:0]        wdata,
  output logic [AW-1:0]        rdata,
  input  logic                 frame_start,
  output logic [BASE_BITS-1:0] act_base,
  output scan_ctrl_t           act_ctrl
);

  localparam int LOW_BITS = AW - BASE_BITS;

  logic [BASE_BITS-1:0] base_q;
  scan_ctrl_t           ctrl_q;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata[LOW_BITS-1:CTRL_W];

  // Programmed copy answers the bus; applied copy drives the scan.
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      ctrl_q   <= '0;
      act_base <= '0;
      act_ctrl <= '0;
      rdata    <= '0;
    end else begin
      if (frame_start) begin
        act_base <= base_q;
        act_ctrl <= ctrl_q;
      end
      if (wr_en) begin
        if (sel_ctrl) ctrl_q <= scan_ctrl_t'(wdata[CTRL_W-1:0]);
        else          base_q <= wdata[AW-1:LOW_BITS];
      end
      if (rd_en)
        rdata <= sel_ctrl ? {{(AW-CTRL_W){1'b0}}, ctrl_q}
                          : {base_q, {LOW_BITS{1'b0}}};
      else
        rdata <= '0;
    end
  end

  // R4: origin read-back never shows low bits
  a_r4_low_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !sel_ctrl) |=> (rdata[LOW_BITS-1:0] == '0));

  // R2: control read-back carries only the two defined bits
  a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_ctrl) |=> (rdata[AW-1:CTRL_W] == '0));

  // R10: applied settings move only on a frame-start pulse
  a_r10_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(act_base) && $stable(act_ctrl)));

endmodule

// File: rtl/fbscan_addr.sv
module fbscan_addr
  import fbscan_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BASE_BITS = 11,
  parameter int H_VIS     = 640,
  parameter int V_VIS     = 480,
  parameter int ROW_WORDS = 1024,
  parameter int COL_W     = $clog2(ROW_WORDS),
  parameter int ROW_W     = $clog2(V_VIS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pix_valid,
  input  logic [COL_W-1:0]     pix_col,
  input  logic [ROW_W-1:0]     pix_row,
  input  logic [BASE_BITS-1:0] base,
  input  scan_ctrl_t           ctrl,
  output logic                 mem_req,
  output logic [AW-1:0]        mem_addr,
  output logic                 s1_valid
);

  localparam int LOW_BITS  = AW - BASE_BITS;
  localparam int STRIDE_SH = $clog2(ROW_WORDS);
  localparam int BYTE_SH   = 2;

  logic             in_range;
  logic             fetch;
  logic [COL_W-1:0] col_eff;
  logic [ROW_W-1:0] row_eff;
  logic [AW-1:0]    word_off;
  logic [AW-1:0]    base_addr;

  always_comb begin
    in_range  = (pix_col < COL_W'(H_VIS)) && (pix_row < ROW_W'(V_VIS));
    fetch     = pix_valid && in_range && ctrl.enable;
    col_eff   = ctrl.rotate ? (COL_W'(H_VIS - 1) - pix_col) : pix_col;
    row_eff   = ctrl.rotate ? (ROW_W'(V_VIS - 1) - pix_row) : pix_row;
    word_off  = (AW'(row_eff) << STRIDE_SH) + AW'(col_eff);
    base_addr = {base, {LOW_BITS{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      s1_valid <= 1'b0;
    end else begin
      mem_req  <= fetch;
      s1_valid <= pix_valid;
      if (fetch) mem_addr <= base_addr + (word_off << BYTE_SH);
    end
  end

  // R3: a request follows a sampled raster position
  a_r3_req_from_valid: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> $past(pix_valid));

  // R6: a disabled display issues no request
  a_r6_idle_no_req: assert property (@(posedge clk) disable iff (rst)
    !ctrl.enable |=> !mem_req);

  // R8: requested column lies in the shown part of the row
  a_r8_col_visible: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[STRIDE_SH+BYTE_SH-1:BYTE_SH] < COL_W'(H_VIS)));

  // R8: requested row lies inside the frame
  a_r8_row_visible: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[STRIDE_SH+ROW_W+BYTE_SH-1:STRIDE_SH+BYTE_SH] < ROW_W'(V_VIS)));

endmodule

// File: rtl/fbscan_unpack.sv
module fbscan_unpack #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s1_valid,
  input  logic          s1_fetch,
  input  logic [DW-1:0] mem_rdata,
  output logic          px_valid,
  output logic [CW-1:0] px_red,
  output logic [CW-1:0] px_green,
  output logic [CW-1:0] px_blue
);

  logic s2_valid;
  logic s2_fetch;
  logic unused_pad;

  assign unused_pad = ^mem_rdata[DW-1:3*CW];

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_fetch <= 1'b0;
      px_valid <= 1'b0;
      px_red   <= '0;
      px_green <= '0;
      px_blue  <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_fetch <= s1_fetch;
      px_valid <= s2_valid;
      if (s2_fetch) begin
        px_red   <= mem_rdata[3*CW-1:2*CW];
        px_green <= mem_rdata[2*CW-1:CW];
        px_blue  <= mem_rdata[CW-1:0];
      end else begin
        px_red   <= '0;
        px_green <= '0;
        px_blue  <= '0;
      end
    end
  end

  // R9: output strobe trails the request stage by two cycles
  a_r9_valid_latency: assert property (@(posedge clk) disable iff (rst)
    px_valid |-> $past(s1_valid, 2));

  // R9: colour is black whenever no pixel is presented
  a_r9_black_when_idle: assert property (@(posedge clk) disable iff (rst)
    !px_valid |-> (px_red == '0 && px_green == '0 && px_blue == '0));

  // R6: no fetch, no colour
  a_r6_black_without_fetch: assert property (@(posedge clk) disable iff (rst)
    !$past(s1_fetch, 2) |-> (px_red == '0 && px_green == '0 && px_blue == '0));

endmodule

// File: rtl/fbscan_top.sv
module fbscan_top
  import fbscan_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int CW        = 8,
  parameter int BASE_BITS = 11,
  parameter int H_VIS     = 640,
  parameter int V_VIS     = 480,
  parameter int ROW_WORDS = 1024,
  parameter int COL_W     = $clog2(ROW_WORDS),
  parameter int ROW_W     = $clog2(V_VIS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [AW-1:0]    reg_wdata,
  output logic [AW-1:0]    reg_rdata,
  input  logic             frame_start,
  input  logic             pix_valid,
  input  logic [COL_W-1:0] pix_col,
  input  logic [ROW_W-1:0] pix_row,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_rdata,
  output logic             px_valid,
  output logic [CW-1:0]    px_red,
  output logic [CW-1:0]    px_green,
  output logic [CW-1:0]    px_blue
);

  logic [BASE_BITS-1:0] act_base;
  scan_ctrl_t           act_ctrl;
  logic                 s1_valid;
  logic                 unused_offset;

  assign unused_offset = ^reg_addr[1:0];

  fbscan_regs #(
    .AW        (AW),
    .BASE_BITS (BASE_BITS)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (reg_wr),
    .rd_en       (reg_rd),
    .sel_ctrl    (reg_addr[2]),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .frame_start (frame_start),
    .act_base    (act_base),
    .act_ctrl    (act_ctrl)
  );

  fbscan_addr #(
    .AW        (AW),
    .BASE_BITS (BASE_BITS),
    .H_VIS     (H_VIS),
    .V_VIS     (V_VIS),
    .ROW_WORDS (ROW_WORDS),
    .COL_W     (COL_W),
    .ROW_W     (ROW_W)
  ) u_addr (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .pix_col   (pix_col),
    .pix_row   (pix_row),
    .base      (act_base),
    .ctrl      (act_ctrl),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .s1_valid  (s1_valid)
  );

  fbscan_unpack #(
    .DW (DW),
    .CW (CW)
  ) u_unpack (
    .clk       (clk),
    .rst       (rst),
    .s1_valid  (s1_valid),
    .s1_fetch  (mem_req),
    .mem_rdata (mem_rdata),
    .px_valid  (px_valid),
    .px_red    (px_red),
    .px_green  (px_green),
    .px_blue   (px_blue)
  );

  // R9: overall position-to-pixel latency is three cycles
  a_r9_end_to_end: assert property (@(posedge clk) disable iff (rst)
    px_valid |-> $past(pix_valid, 3));

endmodule

// File: tb/fbscan_top_tb.sv
`timescale 1ns/1ps
module fbscan_top_tb;

  localparam logic [31:0] MEM_KEY = 32'h9C3A_5AC3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_start = 1'b0;
  logic        pix_valid = 1'b0;
  logic [9:0]  pix_col = '0;
  logic [8:0]  pix_row = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        px_valid;
  logic [7:0]  px_red, px_green, px_blue;

  int n_checks = 0;
  int n_fails  = 0;

  // Bench model of programmed and applied settings
  logic [31:0] p_base = '0, a_base = '0;
  logic [1:0]  p_ctrl = '0, a_ctrl = '0;

  int bc[16];
  int br[16];
  int nb;

  always #2 clk = ~clk;

  fbscan_top u_dut (
    .clk (clk), .rst (rst),
    .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .frame_start (frame_start),
    .pix_valid (pix_valid), .pix_col (pix_col), .pix_row (pix_row),
    .mem_req (mem_req), .mem_addr (mem_addr), .mem_rdata (mem_rdata),
    .px_valid (px_valid), .px_red (px_red), .px_green (px_green), .px_blue (px_blue)
  );

  // Memory answers one cycle after a request; garbage otherwise
  always @(posedge clk)
    mem_rdata <= mem_req ? (mem_addr ^ MEM_KEY) : 32'hDEAD_BEEF;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(int c, int r, bit rot, logic [31:0] base);
    int cc = rot ? 639 - c : c;
    int rr = rot ? 479 - r : r;
    return base + 32'((rr * 1024 + cc) * 4);
  endfunction

  task automatic reg_write(input logic [2:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (off[2]) p_ctrl = d[1:0]; else p_base = d & 32'hFFE0_0000;
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    a_base = p_base; a_ctrl = p_ctrl;
  endtask

  task automatic write_at_frame(input logic [2:0] off, input logic [31:0] d);
    @(negedge clk);
    frame_start = 1'b1; reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
    @(negedge clk);
    frame_start = 1'b0; reg_wr = 1'b0;
    a_base = p_base; a_ctrl = p_ctrl;
    if (off[2]) p_ctrl = d[1:0]; else p_base = d & 32'hFFE0_0000;
  endtask

  task automatic reg_read_check(input logic [2:0] off, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = off;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(reg_rdata == exp, req, "register read-back", reg_rdata, exp);
  endtask

  task automatic add_px(input int c, input int r);
    bc[nb] = c; br[nb] = r; nb++;
  endtask

  // Streams the queued positions on consecutive cycles and checks both ends
  task automatic run_burst(input string req);
    for (int cyc = 0; cyc < nb + 3; cyc++) begin
      @(negedge clk);
      if (cyc >= 1 && cyc - 1 < nb) begin
        int k = cyc - 1;
        bit f = a_ctrl[0] && bc[k] < 640 && br[k] < 480;
        logic [31:0] ea = exp_addr(bc[k], br[k], a_ctrl[1], a_base);
        chk(mem_req == f, req, "mem_req", 32'(mem_req), 32'(f));
        if (f) chk(mem_addr == ea, req, "mem_addr", mem_addr, ea);
      end
      if (cyc >= 3) begin
        int k = cyc - 3;
        bit f = a_ctrl[0] && bc[k] < 640 && br[k] < 480;
        logic [31:0] ed = f ? (exp_addr(bc[k], br[k], a_ctrl[1], a_base) ^ MEM_KEY) : 32'h0;
        logic [31:0] got = {8'h00, px_red, px_green, px_blue};
        chk(px_valid == 1'b1, "R9", "px_valid", 32'(px_valid), 32'h1);
        chk(got == {8'h00, ed[23:0]}, req, "pixel colour (R5)", got, {8'h00, ed[23:0]});
      end
      if (cyc < nb) begin
        pix_valid = 1'b1; pix_col = 10'(bc[cyc]); pix_row = 9'(br[cyc]);
      end else begin
        pix_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(px_valid == 1'b0, "R9", "px_valid after burst", 32'(px_valid), 32'h0);
    nb = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'h0);
    chk(px_valid == 1'b0, "R1", "px_valid after reset", 32'(px_valid), 32'h0);
    chk({px_red, px_green, px_blue} == 24'h0, "R1", "colour after reset",
        32'({px_red, px_green, px_blue}), 32'h0);
    reg_read_check(3'h0, 32'h0, "R1");
    reg_read_check(3'h4, 32'h0, "R1");
    add_px(5, 7);
    run_burst("R1");
  endtask

  task automatic t_regs();
    reg_write(3'h0, 32'h1234_5678);
    reg_read_check(3'h0, 32'h1220_0000, "R4");
    reg_write(3'h4, 32'hFFFF_FFFF);
    reg_read_check(3'h4, 32'h0000_0003, "R2");
    reg_write(3'h7, 32'h0000_0001);        // offset bits 1:0 ignored
    reg_read_check(3'h5, 32'h0000_0001, "R2");
    reg_read_check(3'h2, 32'h1220_0000, "R2");
  endtask

  task automatic t_pending_then_main();
    add_px(5, 7);
    run_burst("R10");                       // enable not yet applied
    frame_pulse();
    add_px(5, 7); add_px(0, 0); add_px(639, 479); add_px(639, 0); add_px(100, 200);
    run_burst("R3");
  endtask

  task automatic t_range();
    add_px(640, 0); add_px(0, 480); add_px(639, 479); add_px(1023, 511); add_px(0, 479);
    run_burst("R8");
  endtask

  task automatic t_rotate();
    reg_write(3'h4, 32'h3);
    add_px(0, 0);
    run_burst("R10");                       // still unrotated
    frame_pulse();
    add_px(0, 0); add_px(639, 479); add_px(10, 20); add_px(700, 3);
    run_burst("R7");
  endtask

  task automatic t_blank();
    reg_write(3'h4, 32'h0);
    frame_pulse();
    add_px(1, 1); add_px(300, 300);
    run_burst("R6");
    reg_write(3'h4, 32'h2);
    frame_pulse();
    add_px(2, 2);
    run_burst("R11");
    reg_write(3'h4, 32'h1);
    frame_pulse();
    add_px(2, 2); add_px(638, 478);
    run_burst("R11");
  endtask

  task automatic t_same_cycle();
    write_at_frame(3'h0, 32'hFFFF_FFFF);
    reg_read_check(3'h0, 32'hFFE0_0000, "R4");
    add_px(639, 479);
    run_burst("R10");                       // old origin still applied
    frame_pulse();
    add_px(639, 479); add_px(0, 0);
    run_burst("R10");
  endtask

  initial begin
    nb = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_pending_then_main();
    t_range();
    t_rotate();
    t_blank();
    t_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule